// File: doc/BRIEF.md
# Three-Stage Sixteen-Bit Load/Store Processor Core

This block is a small processor core that runs a fixed-length 16-bit instruction set. There is no pipeline. Each instruction takes three clocks, one per stage. In the first stage the core reads the instruction word at the program counter into an instruction register. In the second stage it splits that word into an operation and its operand fields. In the third stage it performs the operation and advances the program counter by one. The core holds sixteen 16-bit general registers, a private instruction store indexed by the program counter, and a 256-word data store. Arithmetic results wrap modulo 2^16.

The programming model has seven operations: load an immediate into a register, load a data word into a register, store an immediate to data memory, store a register to data memory, add two registers, add an immediate, and subtract an immediate. Any other opcode stops the core. The halt output then rises and stays high until the next reset.

A test environment fills the instruction store and the data store through two write ports. It observes any register and any data word through two combinational read ports. Reset is synchronous. It clears the program counter, the registers and the stage sequencer. It leaves both stores untouched.

Top module: `ls16_core`

## Requirements
- R1: While `rst` is high at a clock edge, the core returns to its fetch stage with the program counter at 0, all sixteen registers at 0 and `halted` low.
- R2: Each legal instruction takes exactly three clock edges (fetch, decode, execute). Its register or memory result becomes visible after the third edge and not before. The program counter then advances by one.
- R3: Opcode 0000 (load immediate) writes bits [7:0], zero-extended to 16 bits, into the register named by bits [11:8].
- R4: Opcode 0001 (load from memory) copies the data word at the address in bits [7:0] into the register named by bits [11:8].
- R5: Opcode 0010 (store immediate) writes bits [3:0], zero-extended, into the data word at the address in bits [11:4].
- R6: Opcode 0011 (store register) writes the register named by bits [11:8] into the data word at the address in bits [7:0].
- R7: Opcode 0101 (register add) writes dest + src modulo 2^16 into the destination. The destination register is named by bits [11:8] and the source by bits [7:4]. Dest and src may be the same register.
- R8: Opcodes 0100 (add immediate) and 0110 (subtract immediate) replace the register in bits [11:8] with its value plus or minus the zero-extended bits [7:0], modulo 2^16.
- R9: An opcode from 0111 to 1111 raises `halted` at the end of its decode stage, two edges after its fetch began. After that the core writes no register or data word, the program counter stays frozen, and `halted` stays high until reset.
- R10: Reset leaves the data store unchanged. A program loaded while reset is high runs from address 0 once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| halted | output | 1 | High once an undefined opcode has been decoded |
| prog_we | input | 1 | Write strobe into the instruction store |
| prog_addr | input | PC_W | Instruction store write address |
| prog_data | input | 16 | Instruction word to write |
| dload_we | input | 1 | Write strobe into the data store; a core store to the same cycle wins |
| dload_addr | input | 8 | Data store write address |
| dload_data | input | 16 | Data word to write |
| dbg_reg_sel | input | 4 | Register to observe |
| dbg_reg_val | output | 16 | Current value of the selected register |
| dbg_mem_addr | input | 8 | Data word to observe |
| dbg_mem_val | output | 16 | Current value of the selected data word |

## Verification
Assertions check on every cycle the properties that do not depend on the program:
- the fetch, decode, execute order of the stage sequencer;
- the program counter moving by one only after an execute and holding still otherwise;
- a register or data write landing at the written address on the next cycle;
- the halt state being sticky, silent and freezing the counter.

Only the bench scenarios can show that each opcode computes the right value from the right fields. That covers zero extension, wrap-around on add and subtract, and register-to-memory round trips. The bench also checks the exact cycle in which a result appears, and that reset keeps the data store while it clears the registers.

// File: rtl/ls16_pkg.sv
package ls16_pkg;

  localparam int INSTR_W = 16;
  localparam int DATA_W  = 16;
  localparam int OPC_W   = 4;
  localparam int REG_AW  = 4;
  localparam int MEM_AW  = 8;

  typedef logic [INSTR_W-1:0] instr_t;
  typedef logic [DATA_W-1:0]  word_t;

  // Opcode values (bits [15:12] of every instruction)
  localparam logic [OPC_W-1:0] OPC_LDI = 4'h0;
  localparam logic [OPC_W-1:0] OPC_LDM = 4'h1;
  localparam logic [OPC_W-1:0] OPC_STI = 4'h2;
  localparam logic [OPC_W-1:0] OPC_STR = 4'h3;
  localparam logic [OPC_W-1:0] OPC_ADI = 4'h4;
  localparam logic [OPC_W-1:0] OPC_ADR = 4'h5;
  localparam logic [OPC_W-1:0] OPC_SBI = 4'h6;

  typedef enum logic [1:0] {
    ST_FETCH  = 2'd0,
    ST_DECODE = 2'd1,
    ST_EXEC   = 2'd2,
    ST_HALT   = 2'd3
  } stage_e;

  typedef struct packed {
    logic [OPC_W-1:0]  op;
    logic [REG_AW-1:0] rd;     // destination / data register
    logic [REG_AW-1:0] rs;     // second source register
    logic [MEM_AW-1:0] maddr;  // data store address
    word_t             imm;    // zero-extended immediate
  } dec_t;

  function automatic word_t wrap_add(word_t a, word_t b);
    return a + b;
  endfunction

  function automatic word_t wrap_sub(word_t a, word_t b);
    return a - b;
  endfunction

  function automatic logic op_is_legal(logic [OPC_W-1:0] op);
    return op <= OPC_SBI;
  endfunction

  function automatic dec_t decode_instr(instr_t ir);
    dec_t d;
    d.op = ir[15:12];
    d.rd = ir[11:8];
    d.rs = ir[7:4];
    if (ir[15:12] == OPC_STI) begin
      d.maddr = ir[11:4];
      d.imm   = {{(DATA_W-4){1'b0}}, ir[3:0]};
    end else begin
      d.maddr = ir[7:0];
      d.imm   = {{(DATA_W-8){1'b0}}, ir[7:0]};
    end
    return d;
  endfunction

endpackage

// File: rtl/ls16_ctrl.sv
module ls16_ctrl
  import ls16_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic illegal_op,
  output logic fetch_en,
  output logic decode_en,
  output logic exec_en,
  output logic halted
);

  stage_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_FETCH:  st_d = ST_DECODE;
      ST_DECODE: st_d = illegal_op ? ST_HALT : ST_EXEC;
      ST_EXEC:   st_d = ST_FETCH;
      ST_HALT:   st_d = ST_HALT;
      default:   st_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_FETCH;
    else     st_q <= st_d;
  end

  assign fetch_en  = (st_q == ST_FETCH);
  assign decode_en = (st_q == ST_DECODE);
  assign exec_en   = (st_q == ST_EXEC);
  assign halted    = (st_q == ST_HALT);

  // R2: strict three-stage order
  p_fetch_then_decode_r2: assert property (@(posedge clk) disable iff (rst)
    fetch_en |=> decode_en);
  p_decode_then_exec_r2: assert property (@(posedge clk) disable iff (rst)
    decode_en |=> (exec_en || halted));
  p_exec_then_fetch_r2: assert property (@(posedge clk) disable iff (rst)
    exec_en |=> fetch_en);
  p_one_stage_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot({fetch_en, decode_en, exec_en, halted}));
  // R9: undefined opcode halts, and halt is sticky
  p_illegal_halts_r9: assert property (@(posedge clk) disable iff (rst)
    (decode_en && illegal_op) |=> halted);
  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

endmodule

// File: rtl/ls16_fetch.sv
module ls16_fetch
  import ls16_pkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            prog_we,
  input  logic [PC_W-1:0] prog_addr,
  input  instr_t          prog_data,
  input  logic            fetch_en,
  input  logic            adv_en,
  output instr_t          instr_q,
  output logic [PC_W-1:0] pc_q
);

  localparam int DEPTH = 1 << PC_W;

  instr_t imem [DEPTH];

  always_ff @(posedge clk) begin
    if (prog_we) imem[prog_addr] <= prog_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      instr_q <= '0;
      pc_q    <= '0;
    end else begin
      if (fetch_en) instr_q <= imem[pc_q];
      if (adv_en)   pc_q    <= pc_q + 1'b1;
    end
  end

  // R2: counter steps by exactly one after an execute, holds otherwise
  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    adv_en |=> (pc_q == $past(pc_q) + 1'b1));
  p_pc_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !adv_en |=> $stable(pc_q));

endmodule

// File: rtl/ls16_regfile.sv
module ls16_regfile #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_a,
  output logic [DW-1:0] rd_a,
  input  logic [AW-1:0] ra_b,
  output logic [DW-1:0] rd_b,
  input  logic [AW-1:0] ra_dbg,
  output logic [DW-1:0] rd_dbg
);

  localparam int NREG = 1 << AW;

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rd_a   = regs[ra_a];
  assign rd_b   = regs[ra_b];
  assign rd_dbg = regs[ra_dbg];

  // R3: a register write is readable at the written index next cycle
  p_rf_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
    we |=> (regs[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/ls16_dmem.sv
module ls16_dmem #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          core_we,
  input  logic [AW-1:0] core_addr,
  input  logic [DW-1:0] core_wdata,
  input  logic          ext_we,
  input  logic [AW-1:0] ext_addr,
  input  logic [DW-1:0] ext_wdata,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic [AW-1:0] dbg_addr,
  output logic [DW-1:0] dbg_data
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Contents survive reset; the core write wins over the external one
  always_ff @(posedge clk) begin
    if (core_we)     mem[core_addr] <= core_wdata;
    else if (ext_we) mem[ext_addr]  <= ext_wdata;
  end

  assign rd_data  = mem[rd_addr];
  assign dbg_data = mem[dbg_addr];

  // R6: a core store is readable at its address next cycle
  p_core_write_lands_r6: assert property (@(posedge clk) disable iff (rst)
    core_we |=> (mem[$past(core_addr)] == $past(core_wdata)));

endmodule

// File: rtl/ls16_core.sv
module ls16_core
  import ls16_pkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic              halted,
  input  logic              prog_we,
  input  logic [PC_W-1:0]   prog_addr,
  input  logic [15:0]       prog_data,
  input  logic              dload_we,
  input  logic [7:0]        dload_addr,
  input  logic [15:0]       dload_data,
  input  logic [3:0]        dbg_reg_sel,
  output logic [15:0]       dbg_reg_val,
  input  logic [7:0]        dbg_mem_addr,
  output logic [15:0]       dbg_mem_val
);

  logic            fetch_en, decode_en, exec_en;
  instr_t          instr_q;
  logic [PC_W-1:0] pc_q;
  dec_t            dec_now, dec_q;
  logic            illegal_op;

  word_t             rf_a, rf_b, rf_wdata, mem_rdata, mem_wdata;
  logic              rf_we, mem_we;
  logic [MEM_AW-1:0] mem_waddr;

  ls16_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .illegal_op (illegal_op),
    .fetch_en   (fetch_en),
    .decode_en  (decode_en),
    .exec_en    (exec_en),
    .halted     (halted)
  );

  ls16_fetch #(.PC_W(PC_W)) u_fetch (
    .clk       (clk),
    .rst       (rst),
    .prog_we   (prog_we),
    .prog_addr (prog_addr),
    .prog_data (prog_data),
    .fetch_en  (fetch_en),
    .adv_en    (exec_en),
    .instr_q   (instr_q),
    .pc_q      (pc_q)
  );

  // Decode stage: split the held instruction and register the fields
  assign dec_now    = decode_instr(instr_q);
  assign illegal_op = !op_is_legal(dec_now.op);

  always_ff @(posedge clk) begin
    if (rst)            dec_q <= '0;
    else if (decode_en) dec_q <= dec_now;
  end

  ls16_regfile #(.AW(REG_AW), .DW(DATA_W)) u_rf (
    .clk    (clk),
    .rst    (rst),
    .we     (rf_we),
    .waddr  (dec_q.rd),
    .wdata  (rf_wdata),
    .ra_a   (dec_q.rd),
    .rd_a   (rf_a),
    .ra_b   (dec_q.rs),
    .rd_b   (rf_b),
    .ra_dbg (dbg_reg_sel),
    .rd_dbg (dbg_reg_val)
  );

  ls16_dmem #(.AW(MEM_AW), .DW(DATA_W)) u_dmem (
    .clk        (clk),
    .rst        (rst),
    .core_we    (mem_we),
    .core_addr  (mem_waddr),
    .core_wdata (mem_wdata),
    .ext_we     (dload_we),
    .ext_addr   (dload_addr),
    .ext_wdata  (dload_data),
    .rd_addr    (dec_q.maddr),
    .rd_data    (mem_rdata),
    .dbg_addr   (dbg_mem_addr),
    .dbg_data   (dbg_mem_val)
  );

  // Execute stage
  always_comb begin
    rf_we     = 1'b0;
    mem_we    = 1'b0;
    rf_wdata  = '0;
    mem_wdata = '0;
    mem_waddr = dec_q.maddr;
    if (exec_en) begin
      case (dec_q.op)
        OPC_LDI: begin rf_we = 1'b1;  rf_wdata  = dec_q.imm;                end
        OPC_LDM: begin rf_we = 1'b1;  rf_wdata  = mem_rdata;                end
        OPC_STI: begin mem_we = 1'b1; mem_wdata = dec_q.imm;                end
        OPC_STR: begin mem_we = 1'b1; mem_wdata = rf_a;                     end
        OPC_ADI: begin rf_we = 1'b1;  rf_wdata  = wrap_add(rf_a, dec_q.imm); end
        OPC_ADR: begin rf_we = 1'b1;  rf_wdata  = wrap_add(rf_a, rf_b);      end
        OPC_SBI: begin rf_we = 1'b1;  rf_wdata  = wrap_sub(rf_a, dec_q.imm); end
        default: ;
      endcase
    end
  end

  // R9: once halted, nothing is written and the counter is frozen
  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    halted |-> !(rf_we || mem_we));
  p_halt_pc_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(pc_q));
  // R2: an execute writes at most one destination
  p_single_dest_r2: assert property (@(posedge clk) disable iff (rst)
    !(rf_we && mem_we));

endmodule

// File: tb/ls16_core_tb.sv
module ls16_core_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  typedef struct packed {
    logic [15:0] ins;
    logic        is_mem;
    logic [7:0]  where;
    logic [15:0] exp;
    logic [7:0]  req;
  } vec_t;

  // Instruction, then the register/word it should change and its expected value
  localparam vec_t VEC [NVEC] = '{
    '{16'h1119, 1'b0, 8'd1,   16'd23,    8'd4},  // R4 load M25 -> R1
    '{16'h1245, 1'b0, 8'd2,   16'd79,    8'd4},  // R4 load M69 -> R2
    '{16'h5210, 1'b0, 8'd2,   16'd102,   8'd7},  // R7 R2 += R1
    '{16'h3202, 1'b1, 8'd2,   16'd102,   8'd6},  // R6 R2 -> M2
    '{16'h05FF, 1'b0, 8'd5,   16'h00FF,  8'd3},  // R3 zero-extended 0xFF
    '{16'h4501, 1'b0, 8'd5,   16'h0100,  8'd8},  // R8 add imm carries into high byte
    '{16'h6601, 1'b0, 8'd6,   16'hFFFF,  8'd8},  // R8 0 - 1 wraps
    '{16'h4602, 1'b0, 8'd6,   16'h0001,  8'd8},  // R8 0xFFFF + 2 wraps
    '{16'h2AB7, 1'b1, 8'hAB,  16'h0007,  8'd5},  // R5 imm 7 -> M171
    '{16'h5660, 1'b0, 8'd6,   16'h0002,  8'd7},  // R7 same src and dest
    '{16'h0F80, 1'b0, 8'd15,  16'h0080,  8'd3},  // R3 top register
    '{16'h3FFF, 1'b1, 8'hFF,  16'h0080,  8'd6},  // R6 top address
    '{16'h1006, 1'b0, 8'd0,   16'd87,    8'd4},  // R4 load M6 -> R0
    '{16'h50F0, 1'b0, 8'd0,   16'd215,   8'd7},  // R7 R0 += R15
    '{16'h1307, 1'b0, 8'd3,   16'hFFF0,  8'd4},  // R4 load M7 -> R3
    '{16'h5350, 1'b0, 8'd3,   16'h00F0,  8'd7}   // R7 register add wraps
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        halted;
  logic        prog_we = 1'b0;
  logic [7:0]  prog_addr = '0;
  logic [15:0] prog_data = '0;
  logic        dload_we = 1'b0;
  logic [7:0]  dload_addr = '0;
  logic [15:0] dload_data = '0;
  logic [3:0]  dbg_reg_sel = '0;
  logic [15:0] dbg_reg_val;
  logic [7:0]  dbg_mem_addr = '0;
  logic [15:0] dbg_mem_val;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ls16_core #(.PC_W(8)) u_dut (
    .clk (clk), .rst (rst), .halted (halted),
    .prog_we (prog_we), .prog_addr (prog_addr), .prog_data (prog_data),
    .dload_we (dload_we), .dload_addr (dload_addr), .dload_data (dload_data),
    .dbg_reg_sel (dbg_reg_sel), .dbg_reg_val (dbg_reg_val),
    .dbg_mem_addr (dbg_mem_addr), .dbg_mem_val (dbg_mem_val)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Advance n rising edges, then settle at the following falling edge
  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic peek_reg(logic [3:0] idx, output logic [15:0] v);
    dbg_reg_sel = idx; #1; v = dbg_reg_val;
  endtask

  task automatic peek_mem(logic [7:0] a, output logic [15:0] v);
    dbg_mem_addr = a; #1; v = dbg_mem_val;
  endtask

  task automatic put_prog(logic [7:0] a, logic [15:0] d);
    prog_we = 1'b1; prog_addr = a; prog_data = d;
    step(1);
    prog_we = 1'b0;
  endtask

  task automatic put_data(logic [7:0] a, logic [15:0] d);
    dload_we = 1'b1; dload_addr = a; dload_data = d;
    step(1);
    dload_we = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    logic [15:0] v;
    @(negedge clk);
    // Load program and data while reset is held
    for (int i = 0; i < NVEC; i++) put_prog(8'(i), VEC[i].ins);
    put_prog(8'd16, 16'h7000);   // undefined opcode
    put_prog(8'd17, 16'h0955);   // must never run
    put_data(8'd25, 16'd23);
    put_data(8'd69, 16'd79);
    put_data(8'd6,  16'd87);
    put_data(8'd7,  16'hFFF0);

    // R1: reset state
    check("R1 halted in reset", {15'd0, halted}, 16'd0);
    for (int r = 0; r < 16; r++) begin
      peek_reg(4'(r), v);
      check("R1 register cleared", v, 16'd0);
    end

    rst = 1'b0;
    // R2: first result absent after two edges, present after the third
    step(2);
    peek_reg(4'd1, v);
    check("R2 result not before execute", v, 16'd0);
    step(1);
    peek_reg(4'd1, v);
    check("R2 result after third edge", v, 16'd23);

    // Walk the vector table, one instruction per three edges
    for (int i = 1; i < NVEC; i++) begin
      step(3);
      if (VEC[i].is_mem) peek_mem(VEC[i].where, v);
      else               peek_reg(VEC[i].where[3:0], v);
      checks++;
      if (v !== VEC[i].exp) begin
        fails++;
        $display("FAIL R%0d vector %0d: actual %h expected %h",
                 VEC[i].req, i, v, VEC[i].exp);
      end
    end

    // R9: halt appears two edges after the undefined opcode is fetched
    step(1);
    check("R9 not halted after fetch", {15'd0, halted}, 16'd0);
    step(1);
    check("R9 halted after decode", {15'd0, halted}, 16'd1);
    step(10);
    check("R9 halt sticky", {15'd0, halted}, 16'd1);
    peek_reg(4'd9, v);
    check("R9 following instruction not run", v, 16'd0);
    peek_reg(4'd3, v);
    check("R9 registers unchanged while halted", v, 16'h00F0);
    peek_mem(8'd2, v);
    check("R6 sum stored in M2", v, 16'd102);

    // R10: reset clears registers and halt but keeps data
    rst = 1'b1;
    step(1);
    check("R1 halt cleared by reset", {15'd0, halted}, 16'd0);
    peek_reg(4'd0, v);
    check("R1 R0 cleared by reset", v, 16'd0);
    peek_mem(8'd2, v);
    check("R10 data kept across reset", v, 16'd102);
    peek_mem(8'hAB, v);
    check("R10 stored immediate kept", v, 16'h0007);
    put_prog(8'd0, 16'h0A3C);
    put_prog(8'd1, 16'hF123);
    rst = 1'b0;
    step(2);
    peek_reg(4'd10, v);
    check("R2 rerun not before execute", v, 16'd0);
    step(1);
    peek_reg(4'd10, v);
    check("R10 rerun from address 0", v, 16'h003C);
    step(1);
    check("R9 opcode 1111 not yet halted", {15'd0, halted}, 16'd0);
    step(1);
    check("R9 opcode 1111 halts", {15'd0, halted}, 16'd1);
    peek_reg(4'd1, v);
    check("R9 halting word writes nothing", v, 16'd0);

    finish_run();
  end

endmodule